// File: doc/BRIEF.md
# Combinational Integer ALU with Compare and Overflow Flags

A purely combinational arithmetic logic unit. It takes two operands, an operation code and a shift distance, and produces a result word together with three status flags. The operations are addition, subtraction, bitwise AND, bitwise OR, a left shift that fills with zeros and a right shift that fills with the sign bit. A single adder serves both addition and subtraction. Bit 0 of the opcode inverts operand B and also supplies the adder's carry-in.

The signed-overflow flag belongs to the selected add or subtract operation. The adder does not expose the carry into the top bit, so that carry is rebuilt from the top bits of A, the adder's B input and the sum. The flag is that rebuilt carry XOR the carry out. The not-equal and less-than flags come from a separate A−B subtractor, so they are valid under every opcode. The width is a parameter with a default of 32, and the shift distance is log2 of the width.

Top module: `int_alu`

## Requirements
- R1: Opcode 0 gives result = (A + B) modulo 2^WIDTH.
- R2: Opcode 1 gives result = (A − B) modulo 2^WIDTH.
- R3: Opcode 2 gives A AND B, and opcode 3 gives A OR B, bit for bit.
- R4: Opcode 4 gives A shifted left by shamt (0 to WIDTH−1), with zeros entering at bit 0.
- R5: Opcode 5 gives A shifted right by shamt, with copies of A[WIDTH−1] entering at the top.
- R6: Every opcode from 6 to 31 gives a result of zero.
- R7: For opcodes 0 and 1, ovf is 1 exactly when the signed two's-complement result of that operation does not fit in WIDTH bits. For every other opcode, ovf is 0.
- R8: ne is 1 exactly when A differs from B, under every opcode.
- R9: lt is 1 exactly when A < B as signed two's-complement numbers, under every opcode. This holds even when A−B overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 5 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 shift left, 5 arithmetic shift right) |
| shamt_i | input | log2(WIDTH) | Shift distance |
| result_o | output | WIDTH | Selected result |
| ne_o | output | 1 | A differs from B |
| lt_o | output | 1 | A is less than B, signed |
| ovf_o | output | 1 | Signed overflow of the selected add or subtract |

## Verification
Two functions can be active in the same cycle: the compare flags from the dedicated subtractor and the operation chosen by the opcode. The overflow case shows the interaction most clearly. With A = most-negative and B = 1 under the add opcode, the main adder does not overflow, but the compare subtractor does. The sign of the difference is then wrong, and lt must still read 1. The bench provokes this exhaustively on a 4-bit instance, covering every operand pair, every shift distance and opcodes 0 to 7. On the 32-bit instance it uses pseudo-random and boundary operands. Every output is compared with a model computed in signed integer arithmetic.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32,
  parameter int OPW   = 5,
  localparam int SW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OPW-1:0]   op_i,
  input  logic [SW-1:0]    shamt_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ne_o,
  output logic             lt_o,
  output logic             ovf_o
);
  localparam logic [OPW-1:0] OP_ADD = OPW'(0);
  localparam logic [OPW-1:0] OP_SUB = OPW'(1);
  localparam logic [OPW-1:0] OP_AND = OPW'(2);
  localparam logic [OPW-1:0] OP_OR  = OPW'(3);
  localparam logic [OPW-1:0] OP_SLL = OPW'(4);
  localparam logic [OPW-1:0] OP_SRA = OPW'(5);
  localparam int MSB = WIDTH - 1;

  // shared adder: op bit 0 inverts B and supplies carry-in
  logic             inv;
  logic [WIDTH-1:0] bx;
  logic [WIDTH:0]   add_full;
  logic [WIDTH-1:0] sum;
  logic             c_out, c_msb_in, add_ovf;

  assign inv      = op_i[0];
  assign bx       = inv ? ~b_i : b_i;
  assign add_full = {1'b0, a_i} + {1'b0, bx} + {{WIDTH{1'b0}}, inv};
  assign sum      = add_full[WIDTH-1:0];
  assign c_out    = add_full[WIDTH];
  assign c_msb_in = a_i[MSB] ^ bx[MSB] ^ sum[MSB];
  assign add_ovf  = c_msb_in ^ c_out;

  // dedicated compare subtractor
  logic [WIDTH:0]   cmp_full;
  logic [WIDTH-1:0] diff;
  logic             cmp_ovf;

  assign cmp_full = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
  assign diff     = cmp_full[WIDTH-1:0];
  assign cmp_ovf  = (a_i[MSB] ^ ~b_i[MSB] ^ diff[MSB]) ^ cmp_full[WIDTH];
  assign ne_o     = |diff;
  assign lt_o     = diff[MSB] ^ cmp_ovf;

  // barrel shifter; right shift is a left shift of the reversed word
  logic [WIDTH-1:0] a_rev, sra_out;
  logic [WIDTH-1:0] l_st [0:SW];
  logic [WIDTH-1:0] r_st [0:SW];
  logic             sgn;

  assign sgn     = a_i[MSB];
  assign l_st[0] = a_i;
  assign r_st[0] = a_rev;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign a_rev[i]   = a_i[MSB-i];
    assign sra_out[i] = r_st[SW][MSB-i];
  end

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign l_st[k+1] = shamt_i[k] ? {l_st[k][WIDTH-1-S:0], {S{1'b0}}} : l_st[k];
    assign r_st[k+1] = shamt_i[k] ? {r_st[k][WIDTH-1-S:0], {S{sgn}}}  : r_st[k];
  end

  // result select
  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    case (op_i)
      OP_ADD:  begin result_o = sum; ovf_o = add_ovf; end
      OP_SUB:  begin result_o = sum; ovf_o = add_ovf; end
      OP_AND:  result_o = a_i & b_i;
      OP_OR:   result_o = a_i | b_i;
      OP_SLL:  result_o = l_st[SW];
      OP_SRA:  result_o = sra_out;
      default: result_o = '0;
    endcase
  end

  always_comb begin
    AST_NE_MATCH: assert (ne_o == (a_i != b_i));                          // R8
    AST_LT_SIGNED: assert (lt_o == ($signed(a_i) < $signed(b_i)));       // R9
    AST_UNUSED_ZERO: assert (op_i <= OP_SRA || result_o == '0);          // R6
    AST_OVF_ADD: assert (op_i != OP_ADD || ovf_o ==
      ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])));          // R7
    AST_OVF_SUB: assert (op_i != OP_SUB || ovf_o ==
      ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])));          // R7
    AST_SRA_SIGN: assert (op_i != OP_SRA || result_o[MSB] == a_i[MSB]);  // R5
    AST_SLL_LSB: assert (op_i != OP_SLL || shamt_i == '0 || !result_o[0]); // R4
  end
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] a32, b32, r32;
  logic [4:0]  op32, op4;
  logic [4:0]  sh32;
  logic        ne32, lt32, ov32;
  logic [3:0]  a4, b4, r4;
  logic [1:0]  sh4;
  logic        ne4, lt4, ov4;

  int_alu #(.WIDTH(32)) dut_i (
    .a_i(a32), .b_i(b32), .op_i(op32), .shamt_i(sh32),
    .result_o(r32), .ne_o(ne32), .lt_o(lt32), .ovf_o(ov32));

  int_alu #(.WIDTH(4)) dut_small_i (
    .a_i(a4), .b_i(b4), .op_i(op4), .shamt_i(sh4),
    .result_o(r4), .ne_o(ne4), .lt_o(lt4), .ovf_o(ov4));

  function automatic longint sx(longint v, int w);
    return v[w-1] ? v - (longint'(1) << w) : v;
  endfunction

  task automatic model(input longint a, input longint b, input int op, input int sh,
                       input int w, output longint r, output bit ov, output bit ne,
                       output bit lt);
    longint mask = (longint'(1) << w) - 1;
    longint sa = sx(a, w);
    longint sb = sx(b, w);
    longint t;
    ov = 0;
    case (op)
      0: begin t = sa + sb; r = t & mask; ov = (t != sx(r, w)); end
      1: begin t = sa - sb; r = t & mask; ov = (t != sx(r, w)); end
      2: r = a & b;
      3: r = a | b;
      4: r = (a << sh) & mask;
      5: r = (sa >>> sh) & mask;
      default: r = 0;
    endcase
    ne = (a != b);
    lt = (sa < sb);
  endtask

  function automatic string rtag(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic verify(input int w, input longint a, input longint b, input int op,
                        input int sh, input longint gr, input bit gov, input bit gne,
                        input bit glt);
    longint er;
    bit eov, ene, elt;
    model(a, b, op, sh, w, er, eov, ene, elt);
    chk(rtag(op), gr, er);
    chk("R7", longint'(gov), longint'(eov));
    chk("R8", longint'(gne), longint'(ene));
    chk("R9", longint'(glt), longint'(elt));
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input int op,
                       input int sh);
    @(negedge clk);
    a32 = a; b32 = b; op32 = 5'(op); sh32 = 5'(sh);
    @(posedge clk); #1;
    verify(32, longint'(a), longint'(b), op, sh, longint'(r32), ov32, ne32, lt32);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lf;
    a32 = '0; b32 = '0; op32 = '0; sh32 = '0;
    a4 = '0; b4 = '0; op4 = '0; sh4 = '0;
    @(posedge clk); #1;
    // idle state: zero operands, add opcode
    chk("R1", longint'(r32), 0);
    chk("R8", longint'(ne32), 0);
    chk("R7", longint'(ov32), 0);

    // exhaustive sweep on the 4-bit instance, opcodes 0..7
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int sh = 0; sh < 4; sh++) begin
            @(negedge clk);
            a4 = 4'(a); b4 = 4'(b); op4 = 5'(op); sh4 = 2'(sh);
            @(posedge clk); #1;
            verify(4, longint'(a), longint'(b), op, sh, longint'(r4), ov4, ne4, lt4);
          end

    // 32-bit boundary cases
    run32(32'h8000_0000, 32'h0000_0001, 0, 0);   // R9: compare subtraction overflows
    run32(32'h8000_0000, 32'h0000_0001, 1, 0);   // R7: sub overflow
    run32(32'h7FFF_FFFF, 32'h0000_0001, 0, 0);   // R7: add overflow
    run32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 0);   // R7/R9
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);   // R1 carry out without overflow
    run32(32'h8000_0000, 32'h8000_0000, 0, 0);   // R7
    run32(32'h8000_0000, 32'h0, 5, 31);          // R5 full sign fill
    run32(32'h4000_0000, 32'h0, 5, 31);          // R5
    run32(32'h0000_0001, 32'h0, 4, 31);          // R4
    run32(32'hDEAD_BEEF, 32'h0, 4, 0);           // R4 zero distance
    run32(32'h1234_5678, 32'h1234_5678, 31, 7);  // R6 top opcode, R8 equal
    run32(32'h1234_5678, 32'h8765_4321, 16, 3);  // R6

    // pseudo-random sweep over all opcodes
    lf = 32'hACE1_1357;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ra = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rb = (i % 7 == 0) ? ra : lf ^ (ra << 3);
      run32(ra, rb, (i % 9 == 8) ? 6 + int'(lf[4:0] % 26) : i % 8, int'(lf[9:5]));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule